// File: doc/BRIEF.md
# Performance Counter Overflow Monitor

This block holds a small bank of event counters for performance measurement. Each counter counts up by one in every cycle in which its event input is high. The counter's top bit doubles as its overflow flag. Each counter also has a one-bit local control register that arms an overflow condition for that counter. When an armed counter has its top bit set, the counter presents an enabled condition.

A global control register decides what enabled conditions do. One bit lets them raise a level-sensitive interrupt request. A second bit makes them stop every counter in the bank. A third bit lets software stop every counter directly. The request is passed on as taken only while an external enable input is high. If freezing is off and the external enable stays low, a counter can run on past the point where its top bit is all ones, wrap to zero and clear the condition, so the request is lost without ever being taken.

Software reaches all registers through one port. A write lands on the clock edge, and a read returns the addressed register with no added latency. Event source selection and interrupt vectoring belong to the surrounding logic.

Top module: `perf_ovf_monitor`

## Requirements
- R1: After reset, a counter increases by one on each clock edge at which its event input is 1, the bank is not frozen, and no register write targets that counter.
- R2: A write to counter i (address i, for i from 0 to 3) loads the write data into that counter. The write takes effect even if the counter's event input is 1 in the same cycle.
- R3: The overflow flag is counter bit 31. A counter presents an enabled condition only when bit 0 of its local control register (address 4+i) is 1 and its bit 31 is 1.
- R4: `irq_req` is 1 exactly when global control bit 0 (interrupt enable, address 8) is 1 and at least one counter presents an enabled condition.
- R5: `irq_take` equals `irq_req` while `ext_en` is 1, and it is 0 while `ext_en` is 0.
- R6: While global control bit 1 (freeze on condition) is 1 and any enabled condition exists, no counter increments. Writes to the counters still load during this time.
- R7: While global control bit 2 (freeze all) is 1, no counter increments, whatever the conditions.
- R8: Without a freeze, a counter holding 0xFFFFFFFF that sees an event wraps to 0. Its enabled condition and the request it caused then drop.
- R9: A read returns the full counter at addresses 0 to 3, the local control bit zero-extended at addresses 4 to 7, and the three global control bits zero-extended at address 8. Any other address reads as 0.
- R10: A synchronous active-low reset clears every counter and every control register, and so drops `irq_req` and `irq_take`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 4 | One event strobe per counter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address, used for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ext_en | input | 1 | External enable that allows the request to be taken |
| irq_req | output | 1 | Level-sensitive interrupt request |
| irq_take | output | 1 | Request gated by `ext_en` |

## Verification
Counter and control-register updates come from one register stage, so each shows up right after the edge that captures the event or write. `irq_req` and `irq_take` are combinational from those registers, so they move in that same cycle, and `irq_take` also follows `ext_en` with no delay. The bench changes inputs on the falling edge and lets exactly one rising edge act. It then drops the write strobe and the events and points the address at the register to check, and it samples halfway through the high phase, before the next edge can change anything.

// File: rtl/perf_mon_pkg.sv
// Package: shared types for the performance counter overflow monitor.
// Assumes the global control register is exactly three bits wide.
package perf_mon_pkg;
    // Global control fields. The packed order sets the bit positions:
    // irq_en is bit 0, freeze_on_cond is bit 1, frz_all is bit 2.
    typedef struct packed {
        logic frz_all;
        logic freeze_on_cond;
        logic irq_en;
    } gctl_t;

    localparam int unsigned GCTL_W = $bits(gctl_t);
endpackage

// File: rtl/perf_counter.sv
// Module: one event counter together with its one-bit local control register.
// Assumes that the write strobes are already decoded per register and that
// freeze is a single bank-wide signal.
module perf_counter #(
    parameter int unsigned CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             freeze,
    input  logic             cnt_we,
    input  logic             ctl_we,
    input  logic [CTR_W-1:0] wdata,
    output logic [CTR_W-1:0] cnt,
    output logic             cond_arm,
    output logic             cond
);
    localparam int unsigned MSB = CTR_W - 1;

    logic [CTR_W-1:0] cnt_q;
    logic             arm_q;

    // Counter register. A write beats an increment; freeze blocks only increments.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_we)
            cnt_q <= wdata;
        else if (evt && !freeze)
            cnt_q <= cnt_q + CTR_W'(1);
    end

    // Local condition-enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm_q <= 1'b0;
        else if (ctl_we)
            arm_q <= wdata[0];
    end

    // Enabled condition: armed and overflow (top) bit set.
    always_comb begin
        cond = arm_q & cnt_q[MSB];
    end

    assign cnt      = cnt_q;
    assign cond_arm = arm_q;

    // R1: unfrozen event with no write adds exactly one
    p_incr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && evt && !freeze) |=> (cnt_q == $past(cnt_q) + CTR_W'(1)));

    // R2: a write loads the data, whatever the event input does
    p_write_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt_q == $past(wdata)));

    // R6: frozen (or idle) counter without a write keeps its value
    p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && (freeze || !evt)) |=> $stable(cnt_q));

    // R8: a counter at all ones that steps wraps to zero and clears its condition
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && evt && !freeze && (&cnt_q)) |=> (cnt_q == '0 && !cond));
endmodule

// File: rtl/perf_cond_logic.sv
// Module: combines the per-counter conditions with the global control bits
// into the bank freeze, the interrupt request and the taken request.
// Assumes the cond inputs come straight from registered counter state.
module perf_cond_logic
    import perf_mon_pkg::*;
#(
    parameter int unsigned NUM_CTR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] cond,
    input  gctl_t              gctl,
    input  logic               ext_en,
    output logic               freeze,
    output logic               irq_req,
    output logic               irq_take
);
    logic any_cond;

    // Reduce the conditions and derive freeze, request and taken request.
    always_comb begin
        any_cond = |cond;
        freeze   = gctl.frz_all | (gctl.freeze_on_cond & any_cond);
        irq_req  = gctl.irq_en & any_cond;
        irq_take = irq_req & ext_en;
    end

    // R4: a request needs at least one counter reporting a condition
    p_req_needs_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (cond != '0));

    // R5: nothing is taken while the external enable is low
    p_take_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |-> !irq_take);

    // R7: software freeze always holds the bank
    p_frz_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gctl.frz_all |-> freeze);
endmodule

// File: rtl/perf_ovf_monitor.sv
// Module: top of the overflow monitor. Holds the global control register,
// decodes the register port, builds one counter per event input and muxes
// read data. Address map: counters at 0..NUM_CTR-1, local controls at
// NUM_CTR..2*NUM_CTR-1, global control at 2*NUM_CTR. Assumes single-cycle writes.
module perf_ovf_monitor
    import perf_mon_pkg::*;
#(
    parameter int unsigned NUM_CTR = 4,
    parameter int unsigned CTR_W   = 32,
    parameter int unsigned ADDR_W  = $clog2(2 * NUM_CTR + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] evt_i,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [CTR_W-1:0]   reg_wdata,
    output logic [CTR_W-1:0]   reg_rdata,
    input  logic               ext_en,
    output logic               irq_req,
    output logic               irq_take
);
    localparam logic [ADDR_W-1:0] GCTL_ADDR = ADDR_W'(2 * NUM_CTR);

    gctl_t              gctl_q;
    logic               freeze;
    logic [NUM_CTR-1:0] cond;
    logic [NUM_CTR-1:0] arm;
    logic [NUM_CTR-1:0] cnt_we;
    logic [NUM_CTR-1:0] ctl_we;
    logic [CTR_W-1:0]   cnt [NUM_CTR];

    // Global control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gctl_q <= '0;
        else if (reg_we && reg_addr == GCTL_ADDR)
            gctl_q <= gctl_t'(reg_wdata[GCTL_W-1:0]);
    end

    // Write strobe decode for each counter and its local control.
    always_comb begin
        for (int i = 0; i < NUM_CTR; i++) begin
            cnt_we[i] = reg_we && (reg_addr == ADDR_W'(i));
            ctl_we[i] = reg_we && (reg_addr == ADDR_W'(NUM_CTR + i));
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_CTR; g++) begin : g_ctr
            perf_counter #(.CTR_W(CTR_W)) u_ctr (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt      (evt_i[g]),
                .freeze   (freeze),
                .cnt_we   (cnt_we[g]),
                .ctl_we   (ctl_we[g]),
                .wdata    (reg_wdata),
                .cnt      (cnt[g]),
                .cond_arm (arm[g]),
                .cond     (cond[g])
            );
        end
    endgenerate

    perf_cond_logic #(.NUM_CTR(NUM_CTR)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond     (cond),
        .gctl     (gctl_q),
        .ext_en   (ext_en),
        .freeze   (freeze),
        .irq_req  (irq_req),
        .irq_take (irq_take)
    );

    // Read mux; unmapped addresses return zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (reg_addr == ADDR_W'(i))
                reg_rdata = cnt[i];
            if (reg_addr == ADDR_W'(NUM_CTR + i))
                reg_rdata = CTR_W'(arm[i]);
        end
        if (reg_addr == GCTL_ADDR)
            reg_rdata = CTR_W'(gctl_q);
    end

    // R10: the cycle after reset, the control state is cleared and no request is out
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (gctl_q == '0 && !irq_req && !irq_take));
endmodule

// File: tb/perf_ovf_monitor_test.sv
// Bench: walks a vector table (one register or event action per row, then a
// check of one register and both request outputs), followed by directed reset tests.
module perf_ovf_monitor_test;
    localparam int N = 4;
    localparam int W = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt_i = '0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata;
    logic          ext_en = 1'b0;
    logic          irq_req;
    logic          irq_take;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    perf_ovf_monitor #(.NUM_CTR(N), .CTR_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_en(ext_en), .irq_req(irq_req), .irq_take(irq_take)
    );

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [W-1:0]  wdata;
        logic [N-1:0]  evt;
        logic          ext;
        logic [AW-1:0] chk;
        logic [W-1:0]  exp;
        logic          exp_irq;
        logic          exp_take;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd0, 32'd5,          4'b0000, 1'b0, 4'd0, 32'd5,          1'b0, 1'b0, 4'd2},  // R2 load
        '{1'b0, 4'd0, 32'd0,          4'b0001, 1'b0, 4'd0, 32'd6,          1'b0, 1'b0, 4'd1},  // R1 step
        '{1'b1, 4'd0, 32'h100,        4'b0001, 1'b0, 4'd0, 32'h100,        1'b0, 1'b0, 4'd2},  // R2 write beats event
        '{1'b0, 4'd0, 32'd0,          4'b1111, 1'b0, 4'd1, 32'd1,          1'b0, 1'b0, 4'd1},  // R1 all step
        '{1'b1, 4'd2, 32'h7FFFFFFF,   4'b0000, 1'b0, 4'd2, 32'h7FFFFFFF,   1'b0, 1'b0, 4'd2},
        '{1'b1, 4'd6, 32'hFFFF_FFFF,  4'b0000, 1'b0, 4'd6, 32'd1,          1'b0, 1'b0, 4'd9},  // R9 local ctl zero-ext
        '{1'b0, 4'd0, 32'd0,          4'b0100, 1'b0, 4'd2, 32'h80000000,   1'b0, 1'b0, 4'd3},  // R3 crosses, R4 ie off
        '{1'b1, 4'd8, 32'd1,          4'b0000, 1'b0, 4'd8, 32'd1,          1'b1, 1'b0, 4'd4},  // R4 request, R5 not taken
        '{1'b0, 4'd0, 32'd0,          4'b0000, 1'b1, 4'd2, 32'h80000000,   1'b1, 1'b1, 4'd5},  // R5 taken
        '{1'b1, 4'd8, 32'd3,          4'b0000, 1'b1, 4'd8, 32'd3,          1'b1, 1'b1, 4'd9},
        '{1'b0, 4'd0, 32'd0,          4'b1111, 1'b1, 4'd0, 32'h101,        1'b1, 1'b1, 4'd6},  // R6 frozen
        '{1'b1, 4'd0, 32'h55,         4'b0000, 1'b1, 4'd0, 32'h55,         1'b1, 1'b1, 4'd6},  // R6 write while frozen
        '{1'b1, 4'd6, 32'd0,          4'b0000, 1'b1, 4'd6, 32'd0,          1'b0, 1'b0, 4'd3},  // R3 disarm drops request
        '{1'b0, 4'd0, 32'd0,          4'b0001, 1'b1, 4'd0, 32'h56,         1'b0, 1'b0, 4'd6},  // R6 unfrozen again
        '{1'b1, 4'd8, 32'd4,          4'b0000, 1'b1, 4'd8, 32'd4,          1'b0, 1'b0, 4'd9},
        '{1'b0, 4'd0, 32'd0,          4'b1111, 1'b1, 4'd1, 32'd1,          1'b0, 1'b0, 4'd7},  // R7 freeze all
        '{1'b1, 4'd8, 32'd1,          4'b0000, 1'b0, 4'd8, 32'd1,          1'b0, 1'b0, 4'd4},
        '{1'b1, 4'd3, 32'hFFFFFFFF,   4'b0000, 1'b0, 4'd3, 32'hFFFFFFFF,   1'b0, 1'b0, 4'd3},  // R3 unarmed
        '{1'b1, 4'd7, 32'd1,          4'b0000, 1'b0, 4'd7, 32'd1,          1'b1, 1'b0, 4'd5},  // R5 masked
        '{1'b0, 4'd0, 32'd0,          4'b1000, 1'b0, 4'd3, 32'd0,          1'b0, 1'b0, 4'd8},  // R8 wrap loses request
        '{1'b0, 4'd0, 32'd0,          4'b0000, 1'b0, 4'd15, 32'd0,         1'b0, 1'b0, 4'd9}   // R9 unmapped
    };

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Point the address at a register and sample it between edges.
    task automatic peek(input logic [AW-1:0] a, output logic [W-1:0] v);
        reg_we = 1'b0;
        evt_i = '0;
        reg_addr = a;
        #4;
        v = reg_rdata;
    endtask

    initial begin
        logic [W-1:0] v;
        repeat (3) @(posedge clk);
        #1;
        // R10: outputs low while held in reset
        check("R10 irq_req in reset", W'(irq_req), '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 9; a++) begin
            peek(AW'(a), v);
            check("R10 register after reset", v, '0);
        end

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            reg_we = VECS[k].we;
            reg_addr = VECS[k].addr;
            reg_wdata = VECS[k].wdata;
            evt_i = VECS[k].evt;
            ext_en = VECS[k].ext;
            @(posedge clk);
            #1;
            peek(VECS[k].chk, v);
            check($sformatf("R%0d row %0d rdata", VECS[k].req, k), v, VECS[k].exp);
            check($sformatf("R%0d row %0d irq_req", VECS[k].req, k), W'(irq_req), W'(VECS[k].exp_irq));
            check($sformatf("R%0d row %0d irq_take", VECS[k].req, k), W'(irq_take), W'(VECS[k].exp_take));
        end

        // R8 with freeze on condition set: an armed overflow holds instead of wrapping
        @(negedge clk); reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = 32'd3; ext_en = 1'b0;
        @(negedge clk); reg_we = 1'b1; reg_addr = 4'd3; reg_wdata = 32'hFFFFFFFF;
        @(negedge clk); reg_we = 1'b0; evt_i = 4'b1000;
        @(posedge clk); #1;
        peek(4'd3, v);
        check("R6 armed overflow held by freeze", v, 32'hFFFFFFFF);
        check("R5 request pending but not taken", W'({irq_req, irq_take}), W'(2'b10));

        // R10: reset mid-run clears counters, controls and request
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        peek(4'd3, v);
        check("R10 counter cleared", v, '0);
        peek(4'd8, v);
        check("R10 global control cleared", v, '0);
        peek(4'd7, v);
        check("R10 local control cleared", v, '0);
        check("R10 request cleared", W'(irq_req), '0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule